// File: doc/BRIEF.md
# Typed Integer Execute ALU

This block is the integer execute stage of a 32-bit processor. Each cycle it takes an operation code, a left operand, a right operand, an operand type code, a result-extend control and the incoming condition flags. One clock edge later it presents the result, the updated N/Z/C/V flags, a register write-back enable and a jump strobe.

The right operand is first widened from its type width to the full word, by sign extension or by zero fill. The operation is then always computed on the full word. It can load or store a value, run the add and subtract family (including reverse subtract and the borrow forms), compare, bit test, apply a logical operation, shift, or pick the signed or unsigned minimum or maximum. If the extend control is set, the result is also narrowed back to the type width and widened again before it is registered. Operand fetch and memory access belong to neighbouring stages.

Top module: `typed_alu`

## Requirements
- R1: While `rst_n` is low at a clock edge, `result_o`, `flags_o`, `wb_o` and `jump_o` are all cleared to zero on that edge.
- R2: Outputs are registered. Inputs sampled at one rising edge appear at the outputs after that edge and stay there until the next edge.
- R3: The right operand is widened according to `ty_i`: 0 sign-extends from bit 7, 1 zero-fills above bit 7, 2 sign-extends from bit 15, 3 zero-fills above bit 15, and 4 through 7 use the full word unchanged.
- R4: ADD (0x42) gives left+right and ADC (0x43) gives left+right+C. C is set to the carry out of bit 31 and V to signed overflow.
- R5: SUB (0x44) gives left-right, SUBC (0x45) gives left-right-C, SUBR (0x46) gives right-left and SUBRC (0x47) gives right-left-C. After these, C is the borrow (set when the unsigned difference is negative) and V is signed overflow.
- R6: CMP (0x48) sets the flags exactly as SUB does, and BIT (0x49) sets N and Z exactly as AND does. Both hold `wb_o` low.
- R7: AND (0x4A), OR (0x4B) and XOR (0x4C) update N and Z, and pass C and V through from `flags_i`.
- R8: The shift amount is bits 4:0 of the widened right operand. SL (0x4D) and USR (0x50) fill vacated bits with zeros. SLC (0x4E) and SRC (0x51) fill them with the incoming C. SR (0x4F) fills them with bit 31. C takes the last bit shifted out, and a shift by zero keeps C unchanged. V passes through.
- R9: MIN (0x52) and MAX (0x54) choose by signed comparison, and UMIN (0x53) and UMAX (0x55) choose by unsigned comparison. C and V pass through.
- R10: LD (0x40) and LD.J (0x56) return the widened right operand with `wb_o` high, and LD.J also raises `jump_o`. ST (0x41) returns the left operand with `wb_o` low. None of the three changes any flag.
- R11: When `ext_i` is high, the result is re-extended from its type width by the rule of R3 before it is registered.
- R12: On every flag-setting operation, N is bit 31 of the final registered result and Z is set exactly when that result is zero.
- R13: Any opcode outside 0x40 to 0x56 returns zero, holds `wb_o` and `jump_o` low, and leaves the flags equal to `flags_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_i | input | 7 | Operation code |
| lhs_i | input | 32 | Left operand |
| rhs_i | input | 32 | Right operand, before type widening |
| ty_i | input | 3 | Operand type code |
| ext_i | input | 1 | Re-extend the result from the type width |
| flags_i | input | 4 | Incoming flags {N,Z,C,V} |
| result_o | output | 32 | Registered result |
| flags_o | output | 4 | Registered flags {N,Z,C,V} |
| wb_o | output | 1 | Register write-back enable |
| jump_o | output | 1 | Strobe marking a load into the program counter |

## Verification
The bench builds the block with its default 32-bit word. At that width the whole operation space is swept: every opcode from just below the defined range to just above it, six type codes, both settings of the extend control, and two flag inputs with opposite carry. Each combination runs against a grid of boundary operands: zero, one, the byte and halfword sign edges, the word sign edges, all ones, a mixed pattern, and shift counts of 31 and of 33, which wraps to 1. This exercises every carry, borrow, overflow and shift-out edge together with each widening rule. Fixed cases cover reset, the one-cycle latency, and known results for widening and re-extension.

// File: rtl/typed_alu_pkg.sv
// Package: typed_alu_pkg
// Shared constants for the typed ALU: opcode values, operand type codes,
// flag bit positions and the flag-update classes used by the decoder.
// Assumes a 7-bit opcode and a 3-bit type code.
package typed_alu_pkg;
    localparam logic [6:0] OP_LD    = 7'h40;
    localparam logic [6:0] OP_ST    = 7'h41;
    localparam logic [6:0] OP_ADD   = 7'h42;
    localparam logic [6:0] OP_ADC   = 7'h43;
    localparam logic [6:0] OP_SUB   = 7'h44;
    localparam logic [6:0] OP_SUBC  = 7'h45;
    localparam logic [6:0] OP_SUBR  = 7'h46;
    localparam logic [6:0] OP_SUBRC = 7'h47;
    localparam logic [6:0] OP_CMP   = 7'h48;
    localparam logic [6:0] OP_BIT   = 7'h49;
    localparam logic [6:0] OP_AND   = 7'h4A;
    localparam logic [6:0] OP_OR    = 7'h4B;
    localparam logic [6:0] OP_XOR   = 7'h4C;
    localparam logic [6:0] OP_SL    = 7'h4D;
    localparam logic [6:0] OP_SLC   = 7'h4E;
    localparam logic [6:0] OP_SR    = 7'h4F;
    localparam logic [6:0] OP_USR   = 7'h50;
    localparam logic [6:0] OP_SRC   = 7'h51;
    localparam logic [6:0] OP_MIN   = 7'h52;
    localparam logic [6:0] OP_UMIN  = 7'h53;
    localparam logic [6:0] OP_MAX   = 7'h54;
    localparam logic [6:0] OP_UMAX  = 7'h55;
    localparam logic [6:0] OP_LDJ   = 7'h56;

    localparam logic [2:0] TY_S8  = 3'd0;
    localparam logic [2:0] TY_U8  = 3'd1;
    localparam logic [2:0] TY_S16 = 3'd2;
    localparam logic [2:0] TY_U16 = 3'd3;

    localparam int FL_N = 3;
    localparam int FL_Z = 2;
    localparam int FL_C = 1;
    localparam int FL_V = 0;

    typedef enum logic [1:0] {
        UPD_NONE = 2'd0,
        UPD_NZ   = 2'd1,
        UPD_NZC  = 2'd2,
        UPD_NZCV = 2'd3
    } flag_upd_e;
endpackage

// File: rtl/tx_extend.sv
// Module: tx_extend
// Widens a word from the width selected by a type code: sign extension or
// zero fill from 8 or 16 bits, or the full word for any other code.
// Purely combinational. Assumes XLEN >= 16.
module tx_extend #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] val_i,
    input  logic [2:0]      ty_i,
    output logic [XLEN-1:0] val_o
);
    import typed_alu_pkg::*;

    // Select the widening rule for the given type code.
    always_comb begin
        unique case (ty_i)
            TY_S8:   val_o = {{(XLEN-8){val_i[7]}}, val_i[7:0]};
            TY_U8:   val_o = {{(XLEN-8){1'b0}}, val_i[7:0]};
            TY_S16:  val_o = {{(XLEN-16){val_i[15]}}, val_i[15:0]};
            TY_U16:  val_o = {{(XLEN-16){1'b0}}, val_i[15:0]};
            default: val_o = val_i;
        endcase
    end
endmodule

// File: rtl/tx_addsub.sv
// Module: tx_addsub
// Single full-word adder computing a + b + ci. Subtraction is formed by
// the caller, which inverts one operand and chooses the carry-in.
// Returns the carry out of the top bit and the signed overflow.
module tx_addsub #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic            ci_i,
    output logic [XLEN-1:0] sum_o,
    output logic            co_o,
    output logic            ovf_o
);
    // Add with carry, then detect a sign change that the operands cannot explain.
    always_comb begin
        {co_o, sum_o} = {1'b0, a_i} + {1'b0, b_i} + {{XLEN{1'b0}}, ci_i};
        ovf_o = (a_i[XLEN-1] == b_i[XLEN-1]) && (sum_o[XLEN-1] != a_i[XLEN-1]);
    end
endmodule

// File: rtl/tx_shifter.sv
// Module: tx_shifter
// Shifts left or right by amt_i and fills the vacated bits with fill_i.
// Reports the last bit shifted out and whether the amount was non-zero.
// Assumes XLEN is a power of two.
module tx_shifter #(
    parameter int XLEN = 32,
    localparam int SHW = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] val_i,
    input  logic [SHW-1:0]  amt_i,
    input  logic            left_i,
    input  logic            fill_i,
    output logic [XLEN-1:0] res_o,
    output logic            out_bit_o,
    output logic            moved_o
);
    logic [2*XLEN:0] lwide;
    logic [2*XLEN:0] rwide;

    // Shift a widened copy so the fill bits and the lost bit fall out together.
    always_comb begin
        lwide = {1'b0, val_i, {XLEN{fill_i}}} << amt_i;
        rwide = {{XLEN{fill_i}}, val_i, 1'b0} >> amt_i;
        moved_o = (amt_i != '0);
        if (left_i) begin
            res_o     = lwide[2*XLEN-1:XLEN];
            out_bit_o = lwide[2*XLEN];
        end else begin
            res_o     = rwide[XLEN:1];
            out_bit_o = rwide[0];
        end
    end
endmodule

// File: rtl/typed_alu.sv
// Module: typed_alu
// Execute-stage integer ALU. Widens the right operand by type, runs one
// full-word operation, optionally re-extends the result, and registers the
// result, flags {N,Z,C,V}, write-back enable and jump strobe.
// Assumes a synchronous active-low reset and XLEN a power of two >= 16.
module typed_alu #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [6:0]      op_i,
    input  logic [XLEN-1:0] lhs_i,
    input  logic [XLEN-1:0] rhs_i,
    input  logic [2:0]      ty_i,
    input  logic            ext_i,
    input  logic [3:0]      flags_i,
    output logic [XLEN-1:0] result_o,
    output logic [3:0]      flags_o,
    output logic            wb_o,
    output logic            jump_o
);
    import typed_alu_pkg::*;

    localparam int SHW = $clog2(XLEN);

    logic [XLEN-1:0] rhs_w;
    logic [XLEN-1:0] add_a, add_b, add_sum;
    logic            add_ci, add_co, add_ovf, borrow_mode;
    logic [XLEN-1:0] sh_res;
    logic            sh_left, sh_fill, sh_out, sh_moved;
    logic [XLEN-1:0] raw, raw_x, fin;
    logic            c_new, wb_n, jmp_n, lt_s, lt_u;
    flag_upd_e       upd;
    logic [3:0]      flags_n;
    wire             cin = flags_i[FL_C];

    tx_extend #(.XLEN(XLEN)) u_rhs_ext (.val_i(rhs_i), .ty_i(ty_i), .val_o(rhs_w));

    // Route operands into the shared adder for the add and subtract family.
    always_comb begin
        add_a = lhs_i;
        add_b = rhs_w;
        add_ci = 1'b0;
        borrow_mode = 1'b0;
        unique case (op_i)
            OP_ADC:         add_ci = cin;
            OP_SUB, OP_CMP: begin add_b = ~rhs_w; add_ci = 1'b1; borrow_mode = 1'b1; end
            OP_SUBC:        begin add_b = ~rhs_w; add_ci = ~cin; borrow_mode = 1'b1; end
            OP_SUBR:        begin add_a = rhs_w; add_b = ~lhs_i; add_ci = 1'b1; borrow_mode = 1'b1; end
            OP_SUBRC:       begin add_a = rhs_w; add_b = ~lhs_i; add_ci = ~cin; borrow_mode = 1'b1; end
            default:        ;
        endcase
    end

    tx_addsub #(.XLEN(XLEN)) u_addsub (
        .a_i(add_a), .b_i(add_b), .ci_i(add_ci),
        .sum_o(add_sum), .co_o(add_co), .ovf_o(add_ovf)
    );

    // Pick shift direction and the bit that fills vacated positions.
    always_comb begin
        sh_left = (op_i == OP_SL) || (op_i == OP_SLC);
        if (op_i == OP_SLC || op_i == OP_SRC) sh_fill = cin;
        else if (op_i == OP_SR)               sh_fill = lhs_i[XLEN-1];
        else                                  sh_fill = 1'b0;
    end

    tx_shifter #(.XLEN(XLEN)) u_shift (
        .val_i(lhs_i), .amt_i(rhs_w[SHW-1:0]), .left_i(sh_left), .fill_i(sh_fill),
        .res_o(sh_res), .out_bit_o(sh_out), .moved_o(sh_moved)
    );

    assign lt_s = $signed(lhs_i) < $signed(rhs_w);
    assign lt_u = lhs_i < rhs_w;

    // Decode: raw result, which flags change, write-back and jump.
    always_comb begin
        raw = '0;
        upd = UPD_NONE;
        wb_n = 1'b1;
        jmp_n = 1'b0;
        c_new = cin;
        unique case (op_i)
            OP_LD:  raw = rhs_w;
            OP_LDJ: begin raw = rhs_w; jmp_n = 1'b1; end
            OP_ST:  begin raw = lhs_i; wb_n = 1'b0; end
            OP_ADD, OP_ADC, OP_SUB, OP_SUBC, OP_SUBR, OP_SUBRC, OP_CMP: begin
                raw = add_sum;
                upd = UPD_NZCV;
                c_new = add_co ^ borrow_mode;
                wb_n = (op_i != OP_CMP);
            end
            OP_AND, OP_BIT: begin raw = lhs_i & rhs_w; upd = UPD_NZ; wb_n = (op_i != OP_BIT); end
            OP_OR:  begin raw = lhs_i | rhs_w; upd = UPD_NZ; end
            OP_XOR: begin raw = lhs_i ^ rhs_w; upd = UPD_NZ; end
            OP_SL, OP_SLC, OP_SR, OP_USR, OP_SRC: begin
                raw = sh_res;
                upd = UPD_NZC;
                c_new = sh_moved ? sh_out : cin;
            end
            OP_MIN:  begin raw = lt_s ? lhs_i : rhs_w; upd = UPD_NZ; end
            OP_MAX:  begin raw = lt_s ? rhs_w : lhs_i; upd = UPD_NZ; end
            OP_UMIN: begin raw = lt_u ? lhs_i : rhs_w; upd = UPD_NZ; end
            OP_UMAX: begin raw = lt_u ? rhs_w : lhs_i; upd = UPD_NZ; end
            default: wb_n = 1'b0;
        endcase
    end

    tx_extend #(.XLEN(XLEN)) u_res_ext (.val_i(raw), .ty_i(ty_i), .val_o(raw_x));

    // Apply optional re-extension and merge the new flags with the old ones.
    always_comb begin
        fin = ext_i ? raw_x : raw;
        flags_n = flags_i;
        if (upd != UPD_NONE) begin
            flags_n[FL_N] = fin[XLEN-1];
            flags_n[FL_Z] = (fin == '0);
        end
        if (upd == UPD_NZC || upd == UPD_NZCV) flags_n[FL_C] = c_new;
        if (upd == UPD_NZCV)                   flags_n[FL_V] = add_ovf;
    end

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            flags_o  <= '0;
            wb_o     <= 1'b0;
            jump_o   <= 1'b0;
        end else begin
            result_o <= fin;
            flags_o  <= flags_n;
            wb_o     <= wb_n;
            jump_o   <= jmp_n;
        end
    end

    // R6
    cmp_bit_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(op_i) == OP_CMP || $past(op_i) == OP_BIT)) |-> !wb_o);

    // R10
    pass_flags_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(op_i) == OP_LD || $past(op_i) == OP_ST || $past(op_i) == OP_LDJ))
        |-> (flags_o == $past(flags_i)));

    // R10
    jump_implies_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        jump_o |-> wb_o);

    // R9
    umin_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == OP_UMIN && !$past(ext_i)) |-> (result_o <= $past(lhs_i)));

    // R11
    ext_byte_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ext_i) && $past(ty_i) == TY_U8) |-> (result_o[XLEN-1:8] == '0));

    // R13
    undef_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(op_i) < OP_LD || $past(op_i) > OP_LDJ))
        |-> (!wb_o && !jump_o && result_o == '0 && flags_o == $past(flags_i)));
endmodule

// File: tb/typed_alu_test.sv
module typed_alu_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  op_i = '0;
    logic [31:0] lhs_i = '0, rhs_i = '0;
    logic [2:0]  ty_i = '0;
    logic        ext_i = 1'b0;
    logic [3:0]  flags_i = '0;
    logic [31:0] result_o;
    logic [3:0]  flags_o;
    logic        wb_o, jump_o;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    typed_alu #(.XLEN(32)) uut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .lhs_i(lhs_i), .rhs_i(rhs_i),
        .ty_i(ty_i), .ext_i(ext_i), .flags_i(flags_i),
        .result_o(result_o), .flags_o(flags_o), .wb_o(wb_o), .jump_o(jump_o)
    );

    function automatic logic [31:0] widen(logic [31:0] v, logic [2:0] t);
        case (t)
            3'd0: return 32'($signed(v[7:0]));
            3'd1: return {24'd0, v[7:0]};
            3'd2: return 32'($signed(v[15:0]));
            3'd3: return {16'd0, v[15:0]};
            default: return v;
        endcase
    endfunction

    function automatic string req_of(logic [6:0] op);
        if (op == 7'h42 || op == 7'h43) return "R4";
        if (op >= 7'h44 && op <= 7'h47) return "R5";
        if (op == 7'h48 || op == 7'h49) return "R6";
        if (op >= 7'h4A && op <= 7'h4C) return "R7";
        if (op >= 7'h4D && op <= 7'h51) return "R8";
        if (op >= 7'h52 && op <= 7'h55) return "R9";
        if (op == 7'h40 || op == 7'h41 || op == 7'h56) return "R10";
        return "R13";
    endfunction

    // Reference model: {result, flags, wb, jump} from the requirements.
    function automatic logic [37:0] model(logic [6:0] op, logic [31:0] l, logic [31:0] r,
                                          logic [2:0] t, logic ex, logic [3:0] fi);
        logic [31:0] b = widen(r, t);
        logic [31:0] res = 32'd0;
        logic [3:0]  fo = fi;
        logic        c = fi[1], v = fi[0], wb = 1'b1, jp = 1'b0;
        int          cls = 0; // 0 none, 1 NZ, 2 NZC, 3 NZCV
        int          n = int'(b[4:0]);
        logic [32:0] su;
        longint      ss, m, s, bw, du;
        case (op)
            7'h40: res = b;
            7'h56: begin res = b; jp = 1'b1; end
            7'h41: begin res = l; wb = 1'b0; end
            7'h42, 7'h43: begin
                su = {1'b0, l} + {1'b0, b} + ((op == 7'h43) ? 33'(fi[1]) : 33'd0);
                res = su[31:0]; c = su[32];
                ss = longint'($signed(l)) + longint'($signed(b)) + ((op == 7'h43) ? longint'(fi[1]) : 0);
                v = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
                cls = 3;
            end
            7'h44, 7'h45, 7'h46, 7'h47, 7'h48: begin
                bw = (op == 7'h45 || op == 7'h47) ? longint'(fi[1]) : 0;
                if (op == 7'h46 || op == 7'h47) begin
                    m = longint'({32'd0, b}); s = longint'({32'd0, l});
                    ss = longint'($signed(b)) - longint'($signed(l)) - bw;
                end else begin
                    m = longint'({32'd0, l}); s = longint'({32'd0, b});
                    ss = longint'($signed(l)) - longint'($signed(b)) - bw;
                end
                du = m - s - bw;
                res = du[31:0]; c = (du < 0);
                v = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
                cls = 3; wb = (op != 7'h48);
            end
            7'h49: begin res = l & b; cls = 1; wb = 1'b0; end
            7'h4A: begin res = l & b; cls = 1; end
            7'h4B: begin res = l | b; cls = 1; end
            7'h4C: begin res = l ^ b; cls = 1; end
            7'h4D, 7'h4E: begin
                res = l << n;
                if (op == 7'h4E && fi[1]) res = res | ((32'd1 << n) - 32'd1);
                if (n != 0) c = l[32-n];
                cls = 2;
            end
            7'h4F, 7'h50, 7'h51: begin
                if (op == 7'h4F) res = 32'($signed(l) >>> n);
                else res = l >> n;
                if (op == 7'h51 && fi[1]) res = res | ~(32'hFFFF_FFFF >> n);
                if (n != 0) c = l[n-1];
                cls = 2;
            end
            7'h52: begin res = ($signed(l) < $signed(b)) ? l : b; cls = 1; end
            7'h54: begin res = ($signed(l) > $signed(b)) ? l : b; cls = 1; end
            7'h53: begin res = (l < b) ? l : b; cls = 1; end
            7'h55: begin res = (l > b) ? l : b; cls = 1; end
            default: begin res = 32'd0; wb = 1'b0; end
        endcase
        if (ex) res = widen(res, t);
        if (cls >= 1) begin fo[3] = res[31]; fo[2] = (res == 32'd0); end
        if (cls >= 2) fo[1] = c;
        if (cls == 3) fo[0] = v;
        return {res, fo, wb, jp};
    endfunction

    task automatic compare(string tag, logic [37:0] exp);
        checks++;
        if ({result_o, flags_o, wb_o, jump_o} !== exp) begin
            fails++;
            $display("FAIL %s op=%h lhs=%h rhs=%h ty=%0d ext=%0b fi=%b: got res=%h fl=%b wb=%b j=%b, exp res=%h fl=%b wb=%b j=%b",
                     tag, op_i, lhs_i, rhs_i, ty_i, ext_i, flags_i, result_o, flags_o, wb_o, jump_o,
                     exp[37:6], exp[5:2], exp[1], exp[0]);
        end
    endtask

    task automatic drive(logic [6:0] op, logic [31:0] l, logic [31:0] r,
                         logic [2:0] t, logic ex, logic [3:0] fi);
        @(negedge clk);
        op_i = op; lhs_i = l; rhs_i = r; ty_i = t; ext_i = ex; flags_i = fi;
        @(posedge clk);
        #1;
    endtask

    task automatic run_model(string tag, logic [6:0] op, logic [31:0] l, logic [31:0] r,
                             logic [2:0] t, logic ex, logic [3:0] fi);
        drive(op, l, r, t, ex, fi);
        compare(tag, model(op, l, r, t, ex, fi));
    endtask

    task automatic run_fixed(string tag, logic [6:0] op, logic [31:0] l, logic [31:0] r,
                             logic [2:0] t, logic ex, logic [3:0] fi, logic [37:0] exp);
        drive(op, l, r, t, ex, fi);
        compare(tag, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete, got timeout, exp completion");
        finish_run();
    end

    initial begin
        logic [31:0] vals [12];
        logic [3:0]  fis [2];
        vals = '{32'h0, 32'h1, 32'h7F, 32'h80, 32'hFF, 32'h7FFF, 32'h8000,
                 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF, 32'h1234_5678, 32'h21};
        fis = '{4'b0101, 4'b1010};

        // R1: reset clears outputs even with live inputs.
        op_i = 7'h42; lhs_i = 32'h5; rhs_i = 32'h3; ty_i = 3'd4; flags_i = 4'b1111;
        repeat (3) @(posedge clk);
        #1;
        compare("R1", {32'd0, 4'd0, 1'b0, 1'b0});
        @(negedge clk);
        rst_n = 1'b1;

        // R2: new inputs reach the outputs only after the next rising edge.
        drive(7'h42, 32'd10, 32'd20, 3'd4, 1'b0, 4'b0000);
        compare("R2", {32'd30, 4'b0000, 1'b1, 1'b0});
        @(negedge clk);
        op_i = 7'h40; rhs_i = 32'hDEAD_BEEF;
        #1;
        compare("R2", {32'd30, 4'b0000, 1'b1, 1'b0});
        @(posedge clk);
        #1;
        compare("R2", {32'hDEAD_BEEF, 4'b0000, 1'b1, 1'b0});

        // R3: widening of the right operand by type.
        run_fixed("R3", 7'h40, 32'h0, 32'h0000_0080, 3'd0, 1'b0, 4'b0000, {32'hFFFF_FF80, 4'b0000, 1'b1, 1'b0});
        run_fixed("R3", 7'h40, 32'h0, 32'hAB00_0080, 3'd1, 1'b0, 4'b0000, {32'h0000_0080, 4'b0000, 1'b1, 1'b0});
        run_fixed("R3", 7'h40, 32'h0, 32'h0001_8000, 3'd2, 1'b0, 4'b0000, {32'hFFFF_8000, 4'b0000, 1'b1, 1'b0});
        run_fixed("R3", 7'h40, 32'h0, 32'hFFFF_8000, 3'd3, 1'b0, 4'b0000, {32'h0000_8000, 4'b0000, 1'b1, 1'b0});
        run_fixed("R3", 7'h40, 32'h0, 32'hFFFF_8000, 3'd7, 1'b0, 4'b0000, {32'hFFFF_8000, 4'b0000, 1'b1, 1'b0});
        // R11: re-extension of the result from the byte width.
        run_fixed("R11", 7'h42, 32'h7F, 32'h1, 3'd0, 1'b1, 4'b0000, {32'hFFFF_FF80, 4'b1000, 1'b1, 1'b0});
        // R12: Z follows the final, re-extended result.
        run_fixed("R12", 7'h42, 32'hFF, 32'h1, 3'd1, 1'b1, 4'b0000, {32'h0, 4'b0100, 1'b1, 1'b0});
        // R10: jump strobe on LD.J.
        run_fixed("R10", 7'h56, 32'h0, 32'h100, 3'd4, 1'b0, 4'b0110, {32'h100, 4'b0110, 1'b1, 1'b1});
        // R8: shift by zero keeps C.
        run_fixed("R8", 7'h4D, 32'h8000_0001, 32'h0, 3'd4, 1'b0, 4'b0010, {32'h8000_0001, 4'b1010, 1'b1, 1'b0});
        // R5: SUBR 1 - 2 gives a borrow.
        run_fixed("R5", 7'h46, 32'h2, 32'h1, 3'd4, 1'b0, 4'b0000, {32'hFFFF_FFFF, 4'b1010, 1'b1, 1'b0});

        // Sweep: every opcode around the defined range with all controls.
        for (int op = 7'h3F; op <= 7'h57; op++)
            for (int t = 0; t < 6; t++)
                for (int ex = 0; ex < 2; ex++)
                    for (int f = 0; f < 2; f++)
                        for (int a = 0; a < 12; a++)
                            for (int b = 0; b < 12; b++)
                                run_model(req_of(7'(op)), 7'(op), vals[a], vals[b], 3'(t), 1'(ex), fis[f]);

        finish_run();
    end
endmodule